// File: doc/BRIEF.md
# PS/2 Device-to-Host Frame Receiver

This block listens to the clock and data lines of a PS/2 device, such as a keyboard, and recovers the bytes the device sends. It runs entirely in the system clock domain. Each line first passes through a short synchronizer. It then goes through a unanimity filter, which changes its output level only after a fixed run of identical samples. A falling edge of the filtered clock is detected as a one-cycle strobe. On each strobe, the filtered data line is shifted into an 11-bit frame register.

When the eleventh bit of a frame arrives, the frame is checked. Bit 0 is the start bit and must be 0. Bits 1 to 8 are the data byte, least significant bit first. Bit 9 is the parity bit, and the data plus parity must hold an odd number of ones. Bit 10 is the stop bit and must be 1. A good frame delivers its byte with a one-cycle valid strobe. It also shifts a two-byte history word in the same cycle. A bad frame is dropped and raises a one-cycle error strobe. An idle watchdog clears a partly received frame, so that a lost bit cannot misalign the frames that follow.

Top module: `ps2_frame_receiver`

## Requirements
- R1: After reset, `code_o` and `pair_o` are zero, and `code_valid_o` and `frame_err_o` are low.
- R2: A pulse on either PS/2 line that is shorter than `FILT_LEN` (default 8) system clocks has no effect. A clock glitch counts no bit, and a data glitch does not change the sampled bit.
- R3: Bits are captured on falling edges of the filtered PS/2 clock. The frame's bits 1 to 8 form the byte least significant bit first, and that byte appears on `code_o`.
- R4: A good frame raises `code_valid_o` for exactly one system clock.
- R5: A frame whose data plus parity bit (bit 9) hold an even number of ones raises `frame_err_o` for one clock. It gives no valid strobe, and `code_o` and `pair_o` keep their values.
- R6: A frame whose start bit (bit 0) is 1 is rejected as in R5.
- R7: A frame whose stop bit (bit 10) is 0 is rejected as in R5.
- R8: In the cycle `code_valid_o` is high, `pair_o[7:0]` holds the new byte and `pair_o[15:8]` holds the byte of the previous good frame. At all other times `pair_o` holds its value.
- R9: If a frame has started and no filtered clock falling edge occurs for `TIMEOUT_CYCLES` system clocks, the partial frame is dropped without any strobe. The next frame is then received from its start bit.
- R10: `code_valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ps2_clk_i | input | 1 | PS/2 clock line from the device |
| ps2_dat_i | input | 1 | PS/2 data line from the device |
| code_o | output | 8 | Byte of the most recent good frame |
| pair_o | output | 16 | Previous good byte in the upper half, newest in the lower half |
| code_valid_o | output | 1 | One-cycle strobe for a good frame |
| frame_err_o | output | 1 | One-cycle strobe for a rejected frame |

## Verification
Delivering a byte and shifting the two-byte history happen in the same clock. The bench sends back-to-back good frames, some with rejected frames in between. At every valid strobe, the monitor compares `code_o` and both halves of `pair_o` against a model. That model advances only on good frames, so any skew between the two updates shows up at once. Line glitches and a stalled partial frame are placed just before good frames, so a miscounted bit would surface as a wrong byte or a spurious error strobe.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

  localparam int FRAME_BITS = 11;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  // Serial order: start first (bit 0), stop last (bit 10).
  typedef struct packed {
    logic       stop;
    logic       parity;
    logic [7:0] data;
    logic       start;
  } ps2_frame_t;

  function automatic logic frame_good(input ps2_frame_t f);
    return (f.start == 1'b0) && (f.stop == 1'b1) && (^{f.data, f.parity} == 1'b1);
  endfunction

endpackage

// File: rtl/ps2rx_rst_sync.sv
module ps2rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/ps2rx_line_filter.sv
module ps2rx_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q, hist_d;
  logic                   level_q, level_d;

  always_comb begin
    hist_d  = {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
    level_d = level_q;
    if (&hist_q)       level_d = 1'b1;
    else if (~|hist_q) level_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q  <= hist_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/ps2rx_fall_detect.sv
module ps2rx_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;

endmodule

// File: rtl/ps2rx_frame_asm.sv
module ps2rx_frame_asm
  import ps2rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 400_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fall_i,
  input  logic       data_i,
  output logic       good_stb_o,
  output logic       bad_stb_o,
  output logic [7:0] byte_o
);

  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [TMO_W-1:0]      tmo_q, tmo_d;
  logic                  in_frame, tmo_hit, last_bit;
  ps2_frame_t            frame_w;

  always_comb begin
    in_frame = (cnt_q != '0);
    tmo_hit  = in_frame && !fall_i && (tmo_q == TMO_W'(TIMEOUT_CYCLES - 1));
    last_bit = fall_i && (cnt_q == CNT_W'(FRAME_BITS - 1));
    shreg_d  = fall_i ? {data_i, shreg_q[FRAME_BITS-1:1]} : shreg_q;
    frame_w  = ps2_frame_t'(shreg_d);

    cnt_d = cnt_q;
    if (fall_i)       cnt_d = last_bit ? '0 : cnt_q + 1'b1;
    else if (tmo_hit) cnt_d = '0;

    tmo_d = tmo_q;
    if (fall_i || !in_frame || tmo_hit) tmo_d = '0;
    else                                tmo_d = tmo_q + 1'b1;

    good_stb_o = last_bit &&  frame_good(frame_w);
    bad_stb_o  = last_bit && !frame_good(frame_w);
    byte_o     = frame_w.data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      tmo_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      tmo_q   <= tmo_d;
    end
  end

endmodule

// File: rtl/ps2_frame_receiver.sv
module ps2_frame_receiver #(
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_LEN       = 8,
  parameter int TIMEOUT_CYCLES = 400_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ps2_clk_i,
  input  logic        ps2_dat_i,
  output logic [7:0]  code_o,
  output logic [15:0] pair_o,
  output logic        code_valid_o,
  output logic        frame_err_o
);

  logic       rst_n_int;
  logic       clk_lvl, dat_lvl, clk_fall;
  logic       good_stb, bad_stb;
  logic [7:0] rx_byte;

  logic [7:0]  code_q, code_d;
  logic [15:0] pair_q, pair_d;
  logic        valid_q, err_q;

  ps2rx_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_int)
  );

  ps2rx_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt_clk (
    .clk_i(clk_i), .rst_ni(rst_n_int), .line_i(ps2_clk_i), .level_o(clk_lvl)
  );

  ps2rx_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt_dat (
    .clk_i(clk_i), .rst_ni(rst_n_int), .line_i(ps2_dat_i), .level_o(dat_lvl)
  );

  ps2rx_fall_detect u_fall (
    .clk_i(clk_i), .rst_ni(rst_n_int), .level_i(clk_lvl), .fall_o(clk_fall)
  );

  ps2rx_frame_asm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_asm (
    .clk_i(clk_i), .rst_ni(rst_n_int), .fall_i(clk_fall), .data_i(dat_lvl),
    .good_stb_o(good_stb), .bad_stb_o(bad_stb), .byte_o(rx_byte)
  );

  always_comb begin
    code_d = code_q;
    pair_d = pair_q;
    if (good_stb) begin
      code_d = rx_byte;
      pair_d = {pair_q[7:0], rx_byte};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      code_q  <= '0;
      pair_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      code_q  <= code_d;
      pair_q  <= pair_d;
      valid_q <= good_stb;
      err_q   <= bad_stb;
    end
  end

  assign code_o       = code_q;
  assign pair_o       = pair_q;
  assign code_valid_o = valid_q;
  assign frame_err_o  = err_q;

endmodule

// File: rtl/ps2rx_checker.sv
module ps2rx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  code_o,
  input logic [15:0] pair_o,
  input logic        code_valid_o,
  input logic        frame_err_o
);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(code_valid_o && frame_err_o)); // R10

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |=> !code_valid_o); // R4

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o); // R5

  AST_PAIR_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |-> (pair_o[15:8] == $past(pair_o[7:0])) && (pair_o[7:0] == code_o)); // R8

  AST_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_valid_o |-> $stable(pair_o)); // R8

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_valid_o |-> $stable(code_o)); // R3

endmodule

bind ps2_frame_receiver ps2rx_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_o(code_o), .pair_o(pair_o),
  .code_valid_o(code_valid_o), .frame_err_o(frame_err_o)
);

// File: tb/ps2_frame_receiver_test.sv
module ps2_frame_receiver_test;

  localparam int TMO  = 2000;
  localparam int HALF = 40;

  typedef struct {
    bit         is_err;
    logic [7:0] code;
    logic [15:0] pair;
    string      req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps2c = 1'b1, ps2d = 1'b1;
  logic [7:0]  code;
  logic [15:0] pair;
  logic        vld, err;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [15:0] model_pair = '0;
  logic [7:0]  model_code = '0;

  always #2.5 clk = ~clk;

  ps2_frame_receiver #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(ps2c), .ps2_dat_i(ps2d),
    .code_o(code), .pair_o(pair), .code_valid_o(vld), .frame_err_o(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Drives one frame; nbits < 11 gives a partial frame.
  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_start,
                      input bit bad_stop, input bit glitch, input int nbits,
                      input string req);
    logic [10:0] bits;
    exp_t e;
    bits[0]   = bad_start;
    bits[8:1] = d;
    bits[9]   = ~(^d) ^ bad_par;
    bits[10]  = ~bad_stop;
    if (nbits == 11) begin
      e.req = req;
      if (bad_par || bad_start || bad_stop) begin
        e.is_err = 1'b1; e.code = model_code; e.pair = model_pair;
      end else begin
        model_pair = {model_pair[7:0], d};
        model_code = d;
        e.is_err = 1'b0; e.code = d; e.pair = model_pair;
      end
      q.push_back(e);
    end
    for (int i = 0; i < nbits; i++) begin
      ps2d <= bits[i];
      if (glitch && i == 3) begin
        wait_cyc(HALF/2 - 3);
        ps2d <= ~bits[i];
        wait_cyc(3);
        ps2c <= 1'b0;
        wait_cyc(2);
        ps2d <= bits[i];
        wait_cyc(HALF - 2);
      end else begin
        wait_cyc(HALF/2);
        ps2c <= 1'b0;
        wait_cyc(HALF);
      end
      ps2c <= 1'b1;
      wait_cyc(HALF/2);
    end
    ps2d <= 1'b1;
    wait_cyc(3 * HALF);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (vld || err)) begin
      if (q.size() == 0) begin
        check(0, "R2", "unexpected strobe", {vld, err}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(err == e.is_err && vld == !e.is_err, e.req, "strobe kind", {vld, err}, {!e.is_err, e.is_err});
        check(code == e.code, e.req, "code_o", code, e.code);
        check(pair == e.pair, "R8", "pair_o", pair, e.pair);
      end
    end
  end

  initial begin
    fork
      begin
        wait_cyc(150_000);
        check(0, "R4", "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    join_none

    wait_cyc(5);
    #1;
    check(code == 8'h00, "R1", "code after reset", code, 0);
    check(pair == 16'h0, "R1", "pair after reset", pair, 0);
    check(vld == 1'b0,   "R1", "valid after reset", vld, 0);
    check(err == 1'b0,   "R1", "err after reset", err, 0);
    rst_n = 1'b1;
    wait_cyc(20);

    send(8'h1C, 0, 0, 0, 0, 11, "R3");
    send(8'hF0, 0, 0, 0, 0, 11, "R4");
    send(8'hA5, 1, 0, 0, 0, 11, "R5");
    send(8'h3C, 0, 1, 0, 0, 11, "R6");
    send(8'h81, 0, 0, 1, 0, 11, "R7");
    send(8'h5A, 0, 0, 0, 0, 11, "R8");

    // R2: short clock glitch while idle, then a frame
    ps2c <= 1'b0; wait_cyc(5); ps2c <= 1'b1; wait_cyc(50);
    send(8'h12, 0, 0, 0, 0, 11, "R2");
    // R2: data glitch just around a clock fall
    send(8'h77, 0, 0, 0, 1, 11, "R2");

    // R9: partial frame abandoned, next frame aligned
    send(8'hEE, 0, 0, 0, 0, 4, "R9");
    wait_cyc(TMO + 500);
    send(8'h29, 0, 0, 0, 0, 11, "R9");
    send(8'h00, 0, 0, 0, 0, 11, "R3");
    send(8'hFF, 0, 0, 0, 0, 11, "R3");

    wait_cyc(200);
    check(q.size() == 0, "R4", "pending expected strobes", q.size(), 0);
    check(pair == model_pair, "R8", "final pair", pair, model_pair);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule